// File: doc/BRIEF.md
# Shared-Window Coherence Bypass Bridge

This bridge joins two independent processor buses to one memory port and keeps the caches on the two buses coherent. The coherence applies only to a single programmable address window. Every access is examined against that window. Out-of-window accesses go straight to memory. An in-window access from one side is first replayed on the other side as a snoop at the same address. The bridge keeps no record of which lines either cache holds, so every shared access pays the snoop cost.

When the snooped cache holds the line modified, its write-back is captured in a one-line hit buffer and also written to memory. A read that was waiting is then answered from that buffer, with no second memory read. A cache that cannot hold a line shared is always snooped with an invalidating snoop, even for a read. If a side has no coherence hardware at all, an in-window access from the other side raises a one-cycle interrupt to it instead of a snoop. Each side's cache type is chosen by parameter.

Requests are served one at a time. The originating bus is held with a wait signal until the access finishes. When both buses ask at once, they are served in alternation.

Top module: `shared_window_bridge`

## Requirements
- R1: After reset no completion, memory request, snoop or interrupt is driven, and the window is empty: base and span are zero, so every access is out of window.
- R2: A configuration write with selector 0 sets the window base and one with selector 1 sets the span. An address A is in window exactly when base <= A and A - base < span.
- R3: An out-of-window access goes to memory at its own address with no snoop. A read returns the memory line.
- R4: An in-window access from side s snoops the other side at the same address before any memory request. Side s keeps rq_wait high from its request until the cycle of rq_done.
- R5: A snoop into a side of kind 1 (a cache without a shared state) always has sn_inval set. A snoop into a side of kind 2 (a cache with a shared state) has sn_inval set only for a write.
- R6: If the snoop answers sn_dirty=1 on a read, the dirty line is written to memory at the access address. The read then returns that dirty line without a memory read.
- R7: A completing in-window read has rq_shared high. Out-of-window reads and all writes have it low.
- R8: For an in-window access where the other side is of kind 0 (no coherence hardware), the bridge drives no snoop and pulses irq of that other side for exactly one cycle. The access then goes to memory.
- R9: When both sides request in the same cycle, the side not granted last is served first. After reset side 0 wins the first tie.
- R10: sn_valid holds with a stable address until sn_ack. mem_req holds with stable address and direction until mem_ack.
- R11: If the snoop answers dirty on a write, memory receives first the dirty line and then the requester's line, both at the access address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| cfg_we | input | 1 | window register write strobe |
| cfg_sel | input | 1 | 0 writes base, 1 writes span |
| cfg_wdata | input | AW | window register value |
| rq_valid | input | 2 | per-side request, held until rq_done |
| rq_write | input | 2 | per-side direction, 1 = write |
| rq_addr | input | 2 x AW | per-side address |
| rq_wline | input | 2 x LINE_W | per-side write line |
| rq_wait | output | 2 | per-side hold while a request is pending |
| rq_done | output | 2 | per-side one-cycle completion |
| rq_shared | output | 2 | line must be kept shared, valid with rq_done |
| rq_rline | output | LINE_W | read line, valid with rq_done |
| sn_valid | output | 2 | snoop into a side |
| sn_inval | output | 2 | snoop presented as a write (invalidate) |
| sn_addr | output | AW | snoop address |
| sn_ack | input | 2 | snoop answer strobe |
| sn_dirty | input | 2 | snoop hit a modified line, valid with sn_ack |
| sn_line | input | 2 x LINE_W | dirty line written back, valid with sn_ack |
| mem_req | output | 1 | memory request |
| mem_we | output | 1 | memory direction, 1 = write |
| mem_addr | output | AW | memory address |
| mem_wline | output | LINE_W | memory write line |
| mem_ack | input | 1 | memory completion strobe |
| mem_rline | input | LINE_W | memory read line, valid with mem_ack |
| irq | output | 2 | per-side possible-snoop-hit interrupt |

## Verification
Two things can collide in one cycle. The first is two requests arriving together. The bench raises both sides' requests at the same edge and checks the completion order against the alternation rule, using an ordered scoreboard. The second is a dirty snoop hit on the same access that must also read or write memory. Here the bench makes the snoop model answer dirty. It then judges the order and contents of the memory writes, the read count of the memory model, and whether the requester got the written-back line rather than the memory line.

// File: rtl/swb_pkg.sv
package swb_pkg;
   localparam int CACHE_NONE    = 0;
   localparam int CACHE_NOSHARE = 1;
   localparam int CACHE_SHARE   = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SNOOP,
      ST_WBACK,
      ST_MEM,
      ST_DONE
   } swb_state_e;
endpackage

// File: rtl/swb_window.sv
module swb_window #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic          cfg_sel,
   input  logic [AW-1:0] cfg_wdata,
   input  logic [AW-1:0] probe,
   output logic          hit
);
   logic [AW-1:0] base_q;
   logic [AW-1:0] span_q;
   logic [AW-1:0] offset;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         span_q <= '0;
      end else if (cfg_we) begin
         if (cfg_sel) span_q <= cfg_wdata;
         else         base_q <= cfg_wdata;
      end
   end

   // offset form avoids overflow of base + span
   assign offset = probe - base_q;
   assign hit    = (probe >= base_q) && (offset < span_q);
endmodule

// File: rtl/swb_rr_arb.sv
module swb_rr_arb (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] req,
   input  logic       take,
   output logic       any,
   output logic       gnt_idx
);
   logic last_q;

   assign any = |req;

   always_comb begin
      if (req == 2'b11) gnt_idx = ~last_q;
      else              gnt_idx = req[1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            last_q <= 1'b1;
      else if (take && any)  last_q <= gnt_idx;
   end
endmodule

// File: rtl/swb_line_buf.sv
module swb_line_buf #(
   parameter int AW     = 32,
   parameter int LINE_W = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [AW-1:0]     cap_addr,
   input  logic [LINE_W-1:0] cap_line,
   input  logic              release_line,
   output logic              valid,
   output logic [AW-1:0]     addr,
   output logic [LINE_W-1:0] line
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         addr  <= '0;
         line  <= '0;
      end else if (capture) begin
         valid <= 1'b1;
         addr  <= cap_addr;
         line  <= cap_line;
      end else if (release_line) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/shared_window_bridge.sv
module shared_window_bridge
   import swb_pkg::*;
#(
   parameter int AW     = 32,
   parameter int BEAT_W = 64,
   parameter int BEATS  = 4,
   parameter int KIND0  = CACHE_SHARE,
   parameter int KIND1  = CACHE_NOSHARE,
   localparam int LINE_W = BEAT_W * BEATS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic                  cfg_sel,
   input  logic [AW-1:0]         cfg_wdata,
   input  logic [1:0]            rq_valid,
   input  logic [1:0]            rq_write,
   input  logic [1:0][AW-1:0]    rq_addr,
   input  logic [1:0][LINE_W-1:0] rq_wline,
   output logic [1:0]            rq_wait,
   output logic [1:0]            rq_done,
   output logic [1:0]            rq_shared,
   output logic [LINE_W-1:0]     rq_rline,
   output logic [1:0]            sn_valid,
   output logic [1:0]            sn_inval,
   output logic [AW-1:0]         sn_addr,
   input  logic [1:0]            sn_ack,
   input  logic [1:0]            sn_dirty,
   input  logic [1:0][LINE_W-1:0] sn_line,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [AW-1:0]         mem_addr,
   output logic [LINE_W-1:0]     mem_wline,
   input  logic                  mem_ack,
   input  logic [LINE_W-1:0]     mem_rline,
   output logic [1:0]            irq
);
   if (AW < 8)                        begin : g_bad_aw   $error("AW too small");   end
   if (BEAT_W < 8 || BEATS < 1)       begin : g_bad_line $error("bad line shape"); end
   if (KIND0 > 2 || KIND0 < 0)        begin : g_bad_k0   $error("bad KIND0");      end
   if (KIND1 > 2 || KIND1 < 0)        begin : g_bad_k1   $error("bad KIND1");      end

   localparam logic [1:0] HAS_SNOOP = {KIND1 != CACHE_NONE,    KIND0 != CACHE_NONE};
   localparam logic [1:0] NO_SHARE  = {KIND1 == CACHE_NOSHARE, KIND0 == CACHE_NOSHARE};

   swb_state_e        state_q;
   logic              side_q;
   logic              wr_q;
   logic              inwin_q;
   logic [AW-1:0]     addr_q;
   logic [LINE_W-1:0] wline_q;
   logic [LINE_W-1:0] rdata_q;
   logic [1:0]        irq_q;

   logic              any_req;
   logic              gidx;
   logic              win_hit;
   logic              oth;
   logic              buf_cap;
   logic              buf_rel;
   logic              buf_valid;
   logic [AW-1:0]     buf_addr;
   logic [LINE_W-1:0] buf_line;

   assign oth = ~side_q;

   swb_rr_arb u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (rq_valid),
      .take    (state_q == ST_IDLE),
      .any     (any_req),
      .gnt_idx (gidx)
   );

   swb_window #(.AW(AW)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .probe     (rq_addr[gidx]),
      .hit       (win_hit)
   );

   assign buf_cap = (state_q == ST_SNOOP) && sn_ack[oth] && sn_dirty[oth];
   assign buf_rel = (state_q == ST_DONE);

   swb_line_buf #(.AW(AW), .LINE_W(LINE_W)) u_buf (
      .clk          (clk),
      .rst_n        (rst_n),
      .capture      (buf_cap),
      .cap_addr     (addr_q),
      .cap_line     (sn_line[oth]),
      .release_line (buf_rel),
      .valid        (buf_valid),
      .addr         (buf_addr),
      .line         (buf_line)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         side_q  <= 1'b0;
         wr_q    <= 1'b0;
         inwin_q <= 1'b0;
         addr_q  <= '0;
         wline_q <= '0;
         rdata_q <= '0;
         irq_q   <= '0;
      end else begin
         irq_q <= '0;
         unique case (state_q)
            ST_IDLE: if (any_req) begin
               side_q  <= gidx;
               wr_q    <= rq_write[gidx];
               addr_q  <= rq_addr[gidx];
               wline_q <= rq_wline[gidx];
               inwin_q <= win_hit;
               if (win_hit && HAS_SNOOP[~gidx]) begin
                  state_q <= ST_SNOOP;
               end else begin
                  if (win_hit) irq_q[~gidx] <= 1'b1;
                  state_q <= ST_MEM;
               end
            end
            ST_SNOOP: if (sn_ack[oth]) begin
               state_q <= sn_dirty[oth] ? ST_WBACK : ST_MEM;
            end
            ST_WBACK: if (mem_ack) begin
               state_q <= wr_q ? ST_MEM : ST_DONE;
            end
            ST_MEM: if (mem_ack) begin
               rdata_q <= mem_rline;
               state_q <= ST_DONE;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   for (genvar i = 0; i < 2; i++) begin : g_side
      assign rq_done[i]   = (state_q == ST_DONE) && (side_q == i[0]);
      assign rq_shared[i] = rq_done[i] && inwin_q && !wr_q;
      assign rq_wait[i]   = rq_valid[i] && !rq_done[i];
      assign sn_valid[i]  = (state_q == ST_SNOOP) && (oth == i[0]);
      assign sn_inval[i]  = sn_valid[i] && (wr_q || NO_SHARE[i]);
      assign irq[i]       = irq_q[i];
   end

   assign rq_rline  = buf_valid ? buf_line : rdata_q;
   assign sn_addr   = addr_q;
   assign mem_req   = (state_q == ST_MEM) || (state_q == ST_WBACK);
   assign mem_we    = (state_q == ST_WBACK) || wr_q;
   assign mem_addr  = (state_q == ST_WBACK) ? buf_addr : addr_q;
   assign mem_wline = (state_q == ST_WBACK) ? buf_line : wline_q;
endmodule

// File: rtl/swb_checker.sv
module swb_checker #(
   parameter int AW    = 32,
   parameter int KIND0 = 2,
   parameter int KIND1 = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    rq_valid,
   input logic [1:0]    rq_wait,
   input logic [1:0]    rq_done,
   input logic [1:0]    rq_shared,
   input logic [1:0]    sn_valid,
   input logic [1:0]    sn_inval,
   input logic [1:0]    sn_ack,
   input logic [AW-1:0] sn_addr,
   input logic          mem_req,
   input logic          mem_ack,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [1:0]    irq
);
   assert_snoop_before_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && (|sn_valid)));

   assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   assert_one_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rq_done));

   for (genvar i = 0; i < 2; i++) begin : g_chk
      localparam int K = (i == 0) ? KIND0 : KIND1;

      assert_origin_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
         sn_valid[i] |-> rq_valid[1-i] && rq_wait[1-i]);

      assert_snoop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
         sn_valid[i] && !sn_ack[i] |=> sn_valid[i] && $stable(sn_addr));

      assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
         irq[i] |=> !irq[i]);

      assert_shared_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
         rq_shared[i] |-> rq_done[i]);

      if (K == 1) begin : g_noshare
         assert_noshare_inval_R5: assert property (@(posedge clk) disable iff (!rst_n)
            sn_valid[i] |-> sn_inval[i]);
      end
      if (K == 0) begin : g_plain
         assert_no_snoop_plain_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !sn_valid[i]);
      end else begin : g_coh
         assert_no_irq_coherent_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !irq[i]);
      end
   end
endmodule

bind shared_window_bridge swb_checker #(.AW(AW), .KIND0(KIND0), .KIND1(KIND1)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rq_valid  (rq_valid),
   .rq_wait   (rq_wait),
   .rq_done   (rq_done),
   .rq_shared (rq_shared),
   .sn_valid  (sn_valid),
   .sn_inval  (sn_inval),
   .sn_ack    (sn_ack),
   .sn_addr   (sn_addr),
   .mem_req   (mem_req),
   .mem_ack   (mem_ack),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .irq       (irq)
);

// File: tb/shared_window_bridge_bench.sv
`timescale 1ns/1ps

module swb_mem_model (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req,
   input  logic         we,
   input  logic [31:0]  addr,
   input  logic [255:0] wline,
   output logic         ack,
   output logic [255:0] rline,
   output int           rd_cnt,
   output int           wr_cnt,
   output logic [31:0]  last_waddr,
   output logic [255:0] last_wline
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack <= 1'b0; rline <= '0; rd_cnt <= 0; wr_cnt <= 0;
         last_waddr <= '0; last_wline <= '0;
      end else begin
         ack   <= req && !ack;
         rline <= {8{addr ^ 32'hA5A5_0000}};
         if (req && ack) begin
            if (we) begin
               wr_cnt <= wr_cnt + 1; last_waddr <= addr; last_wline <= wline;
            end else begin
               rd_cnt <= rd_cnt + 1;
            end
         end
      end
   end
endmodule

module swb_snoop_model (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         valid,
   input  logic         inval,
   input  logic [31:0]  addr,
   input  logic         dirty_in,
   input  logic [255:0] line_in,
   output logic         ack,
   output logic         dirty,
   output logic [255:0] line,
   output int           cnt,
   output logic [31:0]  last_addr,
   output logic         last_inval
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack <= 1'b0; dirty <= 1'b0; line <= '0; cnt <= 0;
         last_addr <= '0; last_inval <= 1'b0;
      end else begin
         ack   <= valid && !ack;
         dirty <= dirty_in;
         line  <= line_in;
         if (valid && ack) begin
            cnt <= cnt + 1; last_addr <= addr; last_inval <= inval;
         end
      end
   end
endmodule

module shared_window_bridge_bench;
   typedef struct {
      int           side;
      logic [255:0] line;
      logic         shared;
      logic         chk_line;
      string        tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int last_side = 1;
   exp_t sb[$];

   function automatic logic [255:0] pat(input logic [31:0] a);
      return {8{a ^ 32'hA5A5_0000}};
   endfunction

   task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- instance A: side0 shared-capable, side1 no-shared ----------
   logic             cfg_we = 0, cfg_sel = 0;
   logic [31:0]      cfg_wdata = '0;
   logic [1:0]       a_valid = '0, a_write = '0;
   logic [1:0][31:0] a_addr = '0;
   logic [1:0][255:0] a_wl = '0;
   logic [1:0]       a_wait, a_done, a_shared, a_snv, a_sninv, a_snack, a_sndirty, a_irq;
   logic [255:0]     a_rline, a_mwl, a_mrl;
   logic [31:0]      a_snaddr, a_maddr;
   logic [1:0][255:0] a_snline;
   logic             a_mreq, a_mwe, a_mack;
   logic [1:0]       dirty_sel = '0;
   logic [1:0][255:0] dline = '0;
   int               a_rd, a_wr;
   logic [31:0]      a_lwa;
   logic [255:0]     a_lwl;
   int               sn_cnt[2];
   logic [31:0]      sn_la[2];
   logic             sn_li[2];

   shared_window_bridge #(.KIND0(2), .KIND1(1)) u_shared_window_bridge (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .rq_valid(a_valid), .rq_write(a_write), .rq_addr(a_addr), .rq_wline(a_wl),
      .rq_wait(a_wait), .rq_done(a_done), .rq_shared(a_shared), .rq_rline(a_rline),
      .sn_valid(a_snv), .sn_inval(a_sninv), .sn_addr(a_snaddr), .sn_ack(a_snack),
      .sn_dirty(a_sndirty), .sn_line(a_snline),
      .mem_req(a_mreq), .mem_we(a_mwe), .mem_addr(a_maddr), .mem_wline(a_mwl),
      .mem_ack(a_mack), .mem_rline(a_mrl), .irq(a_irq));

   swb_mem_model u_amem (.clk(clk), .rst_n(rst_n), .req(a_mreq), .we(a_mwe), .addr(a_maddr),
      .wline(a_mwl), .ack(a_mack), .rline(a_mrl), .rd_cnt(a_rd), .wr_cnt(a_wr),
      .last_waddr(a_lwa), .last_wline(a_lwl));

   for (genvar i = 0; i < 2; i++) begin : g_asn
      swb_snoop_model u_sn (.clk(clk), .rst_n(rst_n), .valid(a_snv[i]), .inval(a_sninv[i]),
         .addr(a_snaddr), .dirty_in(dirty_sel[i]), .line_in(dline[i]), .ack(a_snack[i]),
         .dirty(a_sndirty[i]), .line(a_snline[i]), .cnt(sn_cnt[i]), .last_addr(sn_la[i]),
         .last_inval(sn_li[i]));
   end

   // ---------------- instance B: side0 shared-capable, side1 no hardware ----------
   logic [1:0]       b_valid = '0;
   logic [1:0][31:0] b_addr = '0;
   logic [1:0][255:0] b_wl = '0;
   logic [1:0]       b_wait, b_done, b_shared, b_snv, b_sninv, b_snack, b_sndirty, b_irq;
   logic [255:0]     b_rline, b_mwl, b_mrl;
   logic [31:0]      b_snaddr, b_maddr;
   logic [1:0][255:0] b_snline;
   logic             b_mreq, b_mwe, b_mack;
   int               b_rd, b_wr, b_sn[2];
   logic [31:0]      b_lwa, b_sla[2];
   logic [255:0]     b_lwl;
   logic             b_sli[2];
   int               b_irq_cyc[2];

   shared_window_bridge #(.KIND0(2), .KIND1(0)) u_plain_bridge (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .rq_valid(b_valid), .rq_write(2'b00), .rq_addr(b_addr), .rq_wline(b_wl),
      .rq_wait(b_wait), .rq_done(b_done), .rq_shared(b_shared), .rq_rline(b_rline),
      .sn_valid(b_snv), .sn_inval(b_sninv), .sn_addr(b_snaddr), .sn_ack(b_snack),
      .sn_dirty(b_sndirty), .sn_line(b_snline),
      .mem_req(b_mreq), .mem_we(b_mwe), .mem_addr(b_maddr), .mem_wline(b_mwl),
      .mem_ack(b_mack), .mem_rline(b_mrl), .irq(b_irq));

   swb_mem_model u_bmem (.clk(clk), .rst_n(rst_n), .req(b_mreq), .we(b_mwe), .addr(b_maddr),
      .wline(b_mwl), .ack(b_mack), .rline(b_mrl), .rd_cnt(b_rd), .wr_cnt(b_wr),
      .last_waddr(b_lwa), .last_wline(b_lwl));

   for (genvar i = 0; i < 2; i++) begin : g_bsn
      swb_snoop_model u_sn (.clk(clk), .rst_n(rst_n), .valid(b_snv[i]), .inval(b_sninv[i]),
         .addr(b_snaddr), .dirty_in(1'b0), .line_in('0), .ack(b_snack[i]),
         .dirty(b_sndirty[i]), .line(b_snline[i]), .cnt(b_sn[i]), .last_addr(b_sla[i]),
         .last_inval(b_sli[i]));
      always @(posedge clk) if (rst_n && b_irq[i]) b_irq_cyc[i]++;
   end

   // ---------------- scoreboard monitor for instance A ----------------
   always @(negedge clk) begin
      if (rst_n && (|a_done)) begin
         if (sb.size() == 0) begin
            check(0, "R9 unexpected completion", {254'd0, a_done}, '0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(a_done[e.side] == 1'b1, {e.tag, " side order"}, {254'd0, a_done}, 256'(1 << e.side));
            check(a_shared[e.side] == e.shared, {"R7 ", e.tag, " shared"}, 256'(a_shared), 256'(e.shared));
            if (e.chk_line)
               check(a_rline == e.line, {e.tag, " line"}, a_rline, e.line);
         end
      end
   end

   task automatic cfg(input bit sel, input logic [31:0] v);
      @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic drive(input int s, input bit w, input logic [31:0] a, input logic [255:0] wl);
      int n = 0;
      a_valid[s] = 1'b1; a_write[s] = w; a_addr[s] = a; a_wl[s] = wl;
      do begin
         @(negedge clk); n++;
         if (n == 2) check(a_wait[s] == 1'b1, "R4 requester held", 256'(a_wait), 256'(1 << s));
      end while (!a_done[s] && n < 200);
      a_valid[s] = 1'b0;
      last_side = s;
   endtask

   task automatic acc(input int s, input bit w, input logic [31:0] a, input logic [255:0] wl,
                      input logic [255:0] exp_line, input bit exp_sh, input string tag);
      exp_t e;
      e.side = s; e.line = exp_line; e.shared = exp_sh; e.chk_line = !w; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      drive(s, w, a, wl);
      @(negedge clk);
   endtask

   task automatic accb(input int s, input logic [31:0] a, output logic [255:0] line);
      int n = 0;
      @(negedge clk);
      b_valid[s] = 1'b1; b_addr[s] = a;
      do begin @(negedge clk); n++; end while (!b_done[s] && n < 200);
      line = b_rline;
      b_valid[s] = 1'b0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int r0, w0, s0, s1, i0;
      logic [255:0] bl;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(a_done == 0 && a_mreq == 0 && a_snv == 0 && a_irq == 0, "R1 reset outputs",
            {a_done, a_snv, a_irq, a_mreq}, '0);

      // R1/R3 empty window: every access out of window
      s1 = sn_cnt[1]; r0 = a_rd;
      acc(0, 0, 32'h1000, '0, pat(32'h1000), 0, "R1 empty window read");
      check(sn_cnt[1] == s1, "R1 no snoop before config", 256'(sn_cnt[1]), 256'(s1));
      check(a_rd == r0 + 1, "R3 memory read", 256'(a_rd), 256'(r0 + 1));

      cfg(0, 32'h1000);
      cfg(1, 32'h0100);

      // R2 window boundaries
      s1 = sn_cnt[1];
      acc(0, 0, 32'h0FFF, '0, pat(32'h0FFF), 0, "R2 below base");
      check(sn_cnt[1] == s1, "R2 below base no snoop", 256'(sn_cnt[1]), 256'(s1));
      acc(0, 0, 32'h1000, '0, pat(32'h1000), 1, "R2 at base");
      check(sn_cnt[1] == s1 + 1, "R2 at base snooped", 256'(sn_cnt[1]), 256'(s1 + 1));
      acc(0, 0, 32'h10FF, '0, pat(32'h10FF), 1, "R2 last in window");
      check(sn_cnt[1] == s1 + 2, "R2 last snooped", 256'(sn_cnt[1]), 256'(s1 + 2));
      acc(0, 0, 32'h1100, '0, pat(32'h1100), 0, "R2 base plus span");
      check(sn_cnt[1] == s1 + 2, "R2 end excluded", 256'(sn_cnt[1]), 256'(s1 + 2));

      // R4/R5 snoop address and invalidate flavour
      acc(0, 0, 32'h1040, '0, pat(32'h1040), 1, "R4 read into no-share side");
      check(sn_la[1] == 32'h1040, "R4 snoop address", 256'(sn_la[1]), 256'h1040);
      check(sn_li[1] == 1'b1, "R5 read into no-share side invalidates", 256'(sn_li[1]), 256'd1);
      s0 = sn_cnt[0];
      acc(1, 0, 32'h1060, '0, pat(32'h1060), 1, "R4 read into share side");
      check(sn_cnt[0] == s0 + 1 && sn_la[0] == 32'h1060, "R4 snoop other side", 256'(sn_la[0]), 256'h1060);
      check(sn_li[0] == 1'b0, "R5 read into share side keeps copy", 256'(sn_li[0]), 256'd0);
      acc(1, 1, 32'h1080, {4{64'h1111_2222_3333_4444}}, '0, 0, "R7 write no shared");
      check(sn_li[0] == 1'b1, "R5 write into share side invalidates", 256'(sn_li[0]), 256'd1);

      // R6 dirty hit on read served from buffer
      dirty_sel[0] = 1'b1; dline[0] = {4{64'hDEAD_BEEF_0000_0001}};
      r0 = a_rd; w0 = a_wr;
      acc(1, 0, 32'h10A0, '0, {4{64'hDEAD_BEEF_0000_0001}}, 1, "R6 read from hit buffer");
      dirty_sel[0] = 1'b0;
      check(a_wr == w0 + 1, "R6 write-back count", 256'(a_wr), 256'(w0 + 1));
      check(a_lwa == 32'h10A0 && a_lwl == {4{64'hDEAD_BEEF_0000_0001}}, "R6 write-back content",
            a_lwl, {4{64'hDEAD_BEEF_0000_0001}});
      check(a_rd == r0, "R6 no memory read", 256'(a_rd), 256'(r0));
      // buffer released: next read comes from memory again
      acc(1, 0, 32'h10C0, '0, pat(32'h10C0), 1, "R6 buffer released");

      // R11 dirty hit on write
      dirty_sel[1] = 1'b1; dline[1] = {4{64'h0BAD_F00D_0000_0002}};
      w0 = a_wr;
      acc(0, 1, 32'h10E0, {4{64'h5555_6666_7777_8888}}, '0, 0, "R11 write after dirty hit");
      dirty_sel[1] = 1'b0;
      check(a_wr == w0 + 2, "R11 two memory writes", 256'(a_wr), 256'(w0 + 2));
      check(a_lwa == 32'h10E0 && a_lwl == {4{64'h5555_6666_7777_8888}}, "R11 requester line last",
            a_lwl, {4{64'h5555_6666_7777_8888}});

      // R9 simultaneous requests, twice
      for (int k = 0; k < 2; k++) begin
         exp_t e1, e2;
         int first;
         first = 1 - last_side;
         e1.side = first;     e1.line = pat(32'h2000 + 32'(first));     e1.shared = 0; e1.chk_line = 1; e1.tag = "R9 tie first";
         e2.side = 1 - first; e2.line = pat(32'h2000 + 32'(1 - first)); e2.shared = 0; e2.chk_line = 1; e2.tag = "R9 tie second";
         sb.push_back(e1); sb.push_back(e2);
         @(negedge clk);
         fork
            drive(0, 0, 32'h2000, '0);
            drive(1, 0, 32'h2001, '0);
         join
         last_side = 1 - first;
         @(negedge clk);
      end

      // R8 side without coherence hardware
      s0 = b_sn[0]; s1 = b_sn[1]; i0 = b_irq_cyc[1]; r0 = b_rd;
      accb(0, 32'h1020, bl);
      check(bl == pat(32'h1020), "R8 read from memory", bl, pat(32'h1020));
      check(b_irq_cyc[1] == i0 + 1, "R8 one-cycle interrupt", 256'(b_irq_cyc[1]), 256'(i0 + 1));
      check(b_sn[1] == s1, "R8 no snoop to plain side", 256'(b_sn[1]), 256'(s1));
      check(b_rd == r0 + 1, "R8 memory read issued", 256'(b_rd), 256'(r0 + 1));
      accb(0, 32'h3000, bl);
      check(b_irq_cyc[1] == i0 + 1, "R8 no interrupt out of window", 256'(b_irq_cyc[1]), 256'(i0 + 1));
      accb(1, 32'h1030, bl);
      check(b_sn[0] == s0 + 1 && b_irq_cyc[0] == 0, "R8 plain side access snoops other",
            256'(b_sn[0]), 256'(s0 + 1));

      repeat (5) @(negedge clk);
      check(sb.size() == 0, "R9 all completions seen", 256'(sb.size()), '0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule